// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block decides whether a small buffer of captured 64-bit words holds states of a known linear feedback sequence. Software or a capture engine fills the buffer through a simple write port. A one-cycle start pulse then launches a scan. The scan begins at a fixed seed. It compares the current sequence state against every buffer word except word 0, one word per clock, and adds each hit to a running total. At the end of each pass over the buffer the total is tested against a goal. If the goal has not been reached and steps remain, the state advances one Galois shift and the buffer is scanned again.

The result is a pass when the goal is reached within the allowed number of steps. It is a fail when the step limit runs out first. Done and pass are held until the next accepted start. The seed, the feedback polynomial, the buffer depth, the match goal and the step limit are all parameters.

Top module: `selftest_seq_checker`

## Requirements
- R1: After a synchronous active-low reset, busy, done and pass are all 0.
- R2: A start pulse seen while busy is 0 begins a run. From the next cycle busy is 1 and done and pass are 0.
- R3: One sequence step shifts the word left by one bit and, when the bit shifted out was 1, XORs in POLY. The seed is the first state searched, before any step.
- R4: Buffer word 0 is never compared. Only words 1 to DEPTH-1 can add to the match total.
- R5: The match total accumulates over all steps of a run and is cleared only by an accepted start.
- R6: The goal is tested after each full pass over words 1 to DEPTH-1. A run whose total reaches MATCH_GOAL in step k (counting from 0) ends with done=1 and pass=1 exactly (k+1)*(DEPTH-1) cycles after the start edge.
- R7: When step LOOP_MAX-1 completes without reaching the goal, the run ends with done=1 and pass=0, LOOP_MAX*(DEPTH-1) cycles after the start edge. The state after LOOP_MAX-1 steps is the last one searched.
- R8: Done and pass hold their values until the next accepted start.
- R9: A start pulse while busy is 1 is ignored. This includes the cycle of the final compare, and the run's result and latency are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | $clog2(DEPTH) | Buffer word index to write |
| wr_data | input | W | Word to store |
| start | input | 1 | One-cycle request to begin a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A run has finished; result valid |
| pass | output | 1 | Finished run met the match goal |

## Verification
A start request can arrive in the same cycle as the final compare of a run, that is, the cycle in which the block decides pass or fail. The bench provokes this by holding start high during exactly the cycle before the last compare edge. It then judges three things: the result and latency equal those of an undisturbed run, done stays high with busy low over the following cycles, and no second run begins. A mid-run start is provoked the same way and must leave the latency unchanged.

// File: rtl/stc_pkg.sv
// Package: shared types for the sequence self-test checker.
// Assumes nothing beyond a single clock domain.
package stc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_DONE = 2'd2
    } phase_t;
endpackage

// File: rtl/stc_word_store.sv
// Module: register array holding the captured words.
// One write port and one combinational read port. Indices at or above
// DEPTH never match a word and are dropped.
module stc_word_store #(
    parameter int W     = 64,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Purpose: store one word when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    // Purpose: present the word under the scan pointer.
    always_comb begin
        rd_data = words[rd_addr];
    end
endmodule

// File: rtl/stc_galois_step.sv
// Module: one Galois shift of the sequence register.
// Left shift by one; if the bit leaving the top was set, XOR the feedback
// constant (the implicit x^W term is not stored).
module stc_galois_step #(
    parameter int          W    = 64,
    parameter logic [W-1:0] POLY = 64'h231D_CEE9_1262_B8A3
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    // Purpose: compute the successor state.
    always_comb begin
        nxt = {cur[W-2:0], 1'b0};
        if (cur[W-1]) begin
            nxt = nxt ^ POLY;
        end
    end
endmodule

// File: rtl/stc_scan_ctrl.sv
// Module: run sequencer and match accumulator.
// Walks words 1..DEPTH-1 once per sequence state, accumulates hits, tests
// the goal at each pass boundary and advances the state or finishes.
// Assumes DEPTH >= 2, LOOP_MAX >= 1, MATCH_GOAL >= 1.
module stc_scan_ctrl
    import stc_pkg::*;
#(
    parameter int           W          = 64,
    parameter int           DEPTH      = 8,
    parameter logic [W-1:0] SEED       = 64'hC0FF_EE00_1234_5678,
    parameter int           MATCH_GOAL = 4,
    parameter int           LOOP_MAX   = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(MATCH_GOAL + DEPTH) + 1,
    localparam int SW = $clog2(LOOP_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  rd_data,
    input  logic [W-1:0]  lfsr_next,
    output logic [AW-1:0] rd_idx,
    output logic [SW-1:0] step_cnt,
    output logic [W-1:0]  lfsr_q,
    output logic          busy,
    output logic          done,
    output logic          pass
);
    localparam logic [AW-1:0] LAST_IDX  = AW'(DEPTH - 1);
    localparam logic [SW-1:0] LAST_STEP = SW'(LOOP_MAX - 1);
    localparam logic [CW-1:0] GOAL      = CW'(MATCH_GOAL);

    phase_t        phase;
    logic [CW-1:0] total;
    logic [CW-1:0] total_nxt;
    logic          hit;
    logic          pass_q;

    // Purpose: compare the current word and form the updated total.
    always_comb begin
        hit       = (rd_data == lfsr_q);
        total_nxt = total + CW'(hit);
    end

    // Purpose: run sequencing, pointer, step count, state and verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            rd_idx   <= '0;
            step_cnt <= '0;
            total    <= '0;
            lfsr_q   <= SEED;
            pass_q   <= 1'b0;
        end else begin
            case (phase)
                PH_SCAN: begin
                    total <= total_nxt;
                    if (rd_idx == LAST_IDX) begin
                        if (total_nxt >= GOAL) begin
                            phase  <= PH_DONE;
                            pass_q <= 1'b1;
                        end else if (step_cnt == LAST_STEP) begin
                            phase  <= PH_DONE;
                            pass_q <= 1'b0;
                        end else begin
                            lfsr_q   <= lfsr_next;
                            step_cnt <= step_cnt + 1'b1;
                            rd_idx   <= AW'(1);
                        end
                    end else begin
                        rd_idx <= rd_idx + 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        phase    <= PH_SCAN;
                        rd_idx   <= AW'(1);
                        step_cnt <= '0;
                        total    <= '0;
                        lfsr_q   <= SEED;
                        pass_q   <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Purpose: decode the phase into the status outputs.
    always_comb begin
        busy = (phase == PH_SCAN);
        done = (phase == PH_DONE);
        pass = pass_q;
    end
endmodule

// File: rtl/selftest_seq_checker.sv
// Module: top of the sequence self-test checker.
// Connects the word store, the Galois step and the run sequencer.
// Assumes the buffer is loaded before start; writes during a run take
// effect on the words not yet compared.
module selftest_seq_checker #(
    parameter int           W          = 64,
    parameter int           DEPTH      = 8,
    parameter logic [W-1:0] SEED       = 64'hC0FF_EE00_1234_5678,
    parameter logic [W-1:0] POLY       = 64'h231D_CEE9_1262_B8A3,
    parameter int           MATCH_GOAL = 4,
    parameter int           LOOP_MAX   = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int SW = $clog2(LOOP_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          pass
);
    logic [AW-1:0] scan_idx;
    logic [SW-1:0] step_cnt;
    logic [W-1:0]  cur_word;
    logic [W-1:0]  lfsr_q;
    logic [W-1:0]  lfsr_nxt;

    stc_word_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (scan_idx),
        .rd_data (cur_word)
    );

    stc_galois_step #(.W(W), .POLY(POLY)) u_step (
        .cur (lfsr_q),
        .nxt (lfsr_nxt)
    );

    stc_scan_ctrl #(
        .W(W), .DEPTH(DEPTH), .SEED(SEED),
        .MATCH_GOAL(MATCH_GOAL), .LOOP_MAX(LOOP_MAX)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_data   (cur_word),
        .lfsr_next (lfsr_nxt),
        .rd_idx    (scan_idx),
        .step_cnt  (step_cnt),
        .lfsr_q    (lfsr_q),
        .busy      (busy),
        .done      (done),
        .pass      (pass)
    );
endmodule

// File: rtl/stc_checker.sv
// Module: property checker bound to the self-test checker top.
// Observes ports plus the scan pointer and step count of the top.
module stc_checker #(
    parameter int DEPTH    = 8,
    parameter int LOOP_MAX = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int SW = $clog2(LOOP_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic [AW-1:0] scan_idx,
    input logic [SW-1:0] step_cnt
);
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !pass));

    a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !pass));

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r4_word0_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((scan_idx != '0) && (scan_idx <= AW'(DEPTH - 1))));

    a_r7_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_cnt < SW'(LOOP_MAX)));

    a_r6_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && !busy));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (scan_idx < AW'(DEPTH - 1)))
        |=> (busy && (scan_idx == AW'($past(scan_idx) + 1'b1))));
endmodule

bind selftest_seq_checker stc_checker #(
    .DEPTH(DEPTH), .LOOP_MAX(LOOP_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .scan_idx (scan_idx),
    .step_cnt (step_cnt)
);

// File: tb/selftest_seq_checker_bench.sv
module selftest_seq_checker_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          W     = 64;
    localparam int          DEPTH = 8;
    localparam int          GOAL  = 3;
    localparam int          LMAX  = 6;
    localparam int          AW    = $clog2(DEPTH);
    localparam logic [63:0] SEED  = 64'hC0FF_EE00_1234_5678;
    localparam logic [63:0] POLY  = 64'h231D_CEE9_1262_B8A3;
    localparam int          PASS_LAT_STEP = DEPTH - 1;
    localparam int          FAIL_LAT      = LMAX * (DEPTH - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          start = 1'b0;
    logic          busy, done, pass;
    int            n_tests = 0;
    int            n_fail = 0;

    selftest_seq_checker #(
        .W(W), .DEPTH(DEPTH), .SEED(SEED), .POLY(POLY),
        .MATCH_GOAL(GOAL), .LOOP_MAX(LOOP_MAX_V())
    ) u_selftest_seq_checker (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .busy(busy), .done(done), .pass(pass)
    );

    function automatic int LOOP_MAX_V();
        return LMAX;
    endfunction

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Sequence model from R3: shift left, XOR POLY when the top bit left.
    function automatic logic [63:0] seq_at(int k);
        logic [63:0] v = SEED;
        for (int i = 0; i < k; i++) begin
            v = v[63] ? ({v[62:0], 1'b0} ^ POLY) : {v[62:0], 1'b0};
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [63:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(idx);
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill_junk();
        for (int i = 0; i < DEPTH; i++) begin
            put(i, 64'h5A5A_0000_DEAD_0000 | 64'(i));
        end
    endtask

    // Launch a run; start is re-raised for one cycle when the cycle count
    // equals poke (poke < 0: never).
    task automatic run(input int poke, output int lat, output logic res,
                       output logic b0, output logic d0);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        b0  = busy;
        d0  = done;
        lat = 0;
        while (!done && lat < 1000) begin
            start = (lat == poke);
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start = 1'b0;
        res = pass;
    endtask

    task automatic t_reset();
        chk(!busy && !done && !pass, "R1", "idle after reset",
            {busy, done, pass}, 0);
    endtask

    task automatic t_seed_first();
        int lat; logic res, b0, d0;
        fill_junk();
        for (int i = 1; i <= GOAL; i++) put(i, seq_at(0));
        run(-1, lat, res, b0, d0);
        chk(b0 && !d0, "R2", "busy next cycle", {b0, d0}, 2);
        chk(res == 1'b1, "R3", "seed searched first", res, 1);
        chk(lat == PASS_LAT_STEP, "R6", "pass latency step0", lat, PASS_LAT_STEP);
    endtask

    task automatic t_word0();
        int lat; logic res, b0, d0;
        fill_junk();
        put(0, seq_at(0));
        for (int i = 1; i < GOAL; i++) put(i, seq_at(0));
        run(-1, lat, res, b0, d0);
        chk(res == 1'b0, "R4", "word0 not counted", res, 0);
        chk(lat == FAIL_LAT, "R4", "fail latency", lat, FAIL_LAT);
    endtask

    task automatic t_accumulate();
        int lat; logic res, b0, d0;
        fill_junk();
        put(4, seq_at(0));
        put(2, seq_at(1));
        put(7, seq_at(2));
        run(-1, lat, res, b0, d0);
        chk(res == 1'b1, "R5", "hits summed over steps", res, 1);
        chk(lat == 3 * PASS_LAT_STEP, "R3", "step rule reaches state 2",
            lat, 3 * PASS_LAT_STEP);
    endtask

    task automatic t_limit();
        int lat; logic res, b0, d0;
        fill_junk();
        for (int i = 1; i <= GOAL; i++) put(i, seq_at(LMAX - 1));
        run(-1, lat, res, b0, d0);
        chk(res == 1'b1, "R7", "last step still searched", res, 1);
        chk(lat == FAIL_LAT, "R6", "pass on last step latency", lat, FAIL_LAT);
        for (int i = 1; i <= GOAL; i++) put(i, seq_at(LMAX));
        run(-1, lat, res, b0, d0);
        chk(res == 1'b0, "R7", "state past limit not searched", res, 0);
        chk(lat == FAIL_LAT, "R7", "fail latency", lat, FAIL_LAT);
    endtask

    task automatic t_hold_restart();
        int lat; logic res, b0, d0;
        fill_junk();
        for (int i = 1; i <= GOAL; i++) put(i, seq_at(1));
        run(-1, lat, res, b0, d0);
        repeat (20) @(negedge clk);
        chk(done && pass && !busy, "R8", "result held", {done, pass, busy}, 6);
        fill_junk();
        run(-1, lat, res, b0, d0);
        chk(b0 && !d0, "R2", "restart clears done", {b0, d0}, 2);
        chk(res == 1'b0, "R8", "new run gives new verdict", res, 0);
    endtask

    task automatic t_ignore();
        int lat; logic res, b0, d0;
        fill_junk();
        run(10, lat, res, b0, d0);
        chk(lat == FAIL_LAT, "R9", "mid-run start ignored", lat, FAIL_LAT);
        for (int i = 1; i <= GOAL; i++) put(i, seq_at(2));
        run(3 * PASS_LAT_STEP - 1, lat, res, b0, d0);
        chk(lat == 3 * PASS_LAT_STEP && res, "R9", "start on final compare",
            lat, 3 * PASS_LAT_STEP);
        repeat (4) @(negedge clk);
        chk(done && !busy && pass, "R9", "no second run", {done, busy, pass}, 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seed_first();
        t_word0();
        t_accumulate();
        t_limit();
        t_hold_restart();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule